// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. Each phase has a high-side and a low-side switch. A 16-bit timebase counts up from zero to the programmed period and then back down to zero. Each phase compares the count against its own duty value, so every pulse is symmetric about the top of the count.

A programmable dead time shortens the active window of both switches in a leg, so the two switches of a leg are never on together. Software writes the period, the three duties and the dead time into shadow registers. The generator copies them into its working set only when the count is at zero.

Each of the six outputs has its own polarity bit and its own enable bit; both act at once. An active-low trip input forces every output to its inactive level at once, without a clock edge. The trip also latches a fault that holds the outputs off until software clears it. A one-cycle sync pulse marks the start of every PWM period.

Top module: `pwm3_ctrl`

## Requirements
- R1: The counter runs 0, 1, …, P, P-1, …, 1 and then repeats, so one PWM period lasts 2·P clock cycles. `sync_pulse` is high for exactly one cycle per period, in the cycle whose outputs reflect a count of zero. After reset P is 0 and `fault` is 0.
- R2: With zero dead time, the high side of a phase is active for 2·min(D,P) cycles per period, centred on the count reaching P. A duty D of 0 gives a high side that is never active. Any D ≥ P gives a high side that is always active.
- R3: With dead time T, the high side is active for max(0, 2·(min(D,P)−T)) cycles and the low side for max(0, 2·(P−min(D,P)−T)) cycles per period. The two sides of a leg are never active in the same cycle.
- R4: A write to the period, a duty or the dead time does not change the period in progress. It takes effect from the period that follows the next zero count.
- R5: Polarity register bits [2:0] belong to `gate_hi[2:0]` and bits [5:3] belong to `gate_lo[2:0]`. A bit value of 1 makes that pin active-low, so the pin equals the active state XOR the bit. The bits act at once.
- R6: Enable register bits [2:0] belong to `gate_hi[2:0]` and bits [5:3] belong to `gate_lo[2:0]`. A value of 1 enables the output. A disabled pin sits at its inactive level, which is its polarity bit. The register resets to 0, so every pin is 0 after reset.
- R7: While `trip_n` is low, every pin is at its inactive level, with no clock edge needed.
- R8: A low `trip_n` sets `fault` within 3 clock cycles. While `fault` is 1, every pin stays inactive. Only a write to address 7 clears `fault`, and only while `trip_n` is high. A clear written while `trip_n` is low is ignored.
- R9: Register addresses: 0 is the period, 1, 2 and 3 are the duties of phases 0, 1 and 2, 4 is the dead time, 5 is polarity, 6 is enable and 7 clears the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_n | input | 1 | Active-low shutdown request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| gate_hi | output | 3 | High-side gate pins, one per phase |
| gate_lo | output | 3 | Low-side gate pins, one per phase |
| sync_pulse | output | 1 | One-cycle period marker |
| fault | output | 1 | Sticky trip indication |

## Verification
The hardest situation to reach is a register write that lands in the middle of a running period: it must leave that period's pulses untouched and change only the next one. To reach it, the bench starts a pulse-width measurement at a sync pulse and, in parallel, writes a new duty a few cycles later. It then checks that the measured window still shows the old width and that the window right after it shows the new width. A second hard case is the fault latch. A clear is issued while the trip is still low, and the trip is then released without a clear. Both steps must leave the outputs dark, and only a later clear may restore them.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CNT_W = 16;
  localparam int N_PH  = 3;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_PERIOD = 3'd0;
  localparam logic [ADR_W-1:0] ADR_DUTY0  = 3'd1;
  localparam logic [ADR_W-1:0] ADR_DEAD   = 3'd4;
  localparam logic [ADR_W-1:0] ADR_POL    = 3'd5;
  localparam logic [ADR_W-1:0] ADR_ENA    = 3'd6;
  localparam logic [ADR_W-1:0] ADR_CLR    = 3'd7;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NPH = N_PH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trip_n,
  input  logic                     wr_en,
  input  logic [ADR_W-1:0]         wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic [CW-1:0]            sh_per,
  output logic [CW-1:0]            sh_dt,
  output logic [NPH-1:0][CW-1:0]   sh_duty,
  output logic [2*NPH-1:0]         pol,
  output logic [2*NPH-1:0]         ena,
  output logic                     fault
);
  localparam int OW = 2 * NPH;

  logic [CW-1:0]          per_d, dt_d;
  logic [NPH-1:0][CW-1:0] duty_d;
  logic [OW-1:0]          pol_d, ena_d;
  logic                   fault_d;
  logic [1:0]             trip_s;
  logic                   clr_wr;

  assign clr_wr = wr_en && (wr_addr == ADR_CLR);

  always_comb begin
    per_d  = sh_per;
    dt_d   = sh_dt;
    duty_d = sh_duty;
    pol_d  = pol;
    ena_d  = ena;
    if (wr_en) begin
      if (wr_addr == ADR_PERIOD) per_d = wr_data;
      if (wr_addr == ADR_DEAD)   dt_d  = wr_data;
      if (wr_addr == ADR_POL)    pol_d = wr_data[OW-1:0];
      if (wr_addr == ADR_ENA)    ena_d = wr_data[OW-1:0];
      for (int k = 0; k < NPH; k++)
        if (wr_addr == ADR_DUTY0 + ADR_W'(k)) duty_d[k] = wr_data;
    end
    fault_d = !trip_s[1] || (fault && !(clr_wr && trip_s[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per  <= '0;
      sh_dt   <= '0;
      sh_duty <= '0;
      pol     <= '0;
      ena     <= '0;
      fault   <= 1'b0;
      trip_s  <= 2'b11;
    end else begin
      sh_per  <= per_d;
      sh_dt   <= dt_d;
      sh_duty <= duty_d;
      pol     <= pol_d;
      ena     <= ena_d;
      fault   <= fault_d;
      trip_s  <= {trip_s[0], trip_n};
    end
  end
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NPH = N_PH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          sh_per,
  input  logic [CW-1:0]          sh_dt,
  input  logic [NPH-1:0][CW-1:0] sh_duty,
  output logic [CW-1:0]          cnt,
  output logic                   up,
  output logic [CW-1:0]          per_a,
  output logic [CW-1:0]          dt_a,
  output logic [NPH-1:0][CW-1:0] duty_a,
  output logic                   sync_q
);
  logic [CW-1:0] cnt_d;
  logic          up_d;
  logic          at_zero;

  assign at_zero = (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    up_d  = up;
    if (at_zero) begin
      up_d  = 1'b1;
      cnt_d = (sh_per != '0) ? CW'(1) : '0;
    end else if (up) begin
      if (cnt >= per_a) begin
        up_d  = 1'b0;
        cnt_d = cnt - 1'b1;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end else begin
      cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      up     <= 1'b1;
      sync_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      up     <= up_d;
      sync_q <= at_zero;
    end
  end

  // Working set, loaded only at the zero count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a  <= '0;
      dt_a   <= '0;
      duty_a <= '0;
    end else if (at_zero) begin
      per_a  <= sh_per;
      dt_a   <= sh_dt;
      duty_a <= sh_duty;
    end
  end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
  import pwm3_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] dt,
  output logic          hi_q,
  output logic          lo_q
);
  localparam int SW = CW + 2;

  logic [CW-1:0]        dc;
  logic signed [SW-1:0] cnt_s, th_hi, th_lo;
  logic                 over_hi, over_lo;

  always_comb begin
    dc      = (duty > per) ? per : duty;
    cnt_s   = $signed({2'b00, cnt});
    th_hi   = $signed({2'b00, per}) - $signed({2'b00, dc}) + $signed({2'b00, dt});
    th_lo   = $signed({2'b00, per}) - $signed({2'b00, dc}) - $signed({2'b00, dt});
    over_hi = up ? (cnt_s > th_hi) : (cnt_s >= th_hi);
    over_lo = up ? (cnt_s > th_lo) : (cnt_s >= th_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= over_hi;
      lo_q <= !over_lo;
    end
  end
endmodule

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl
  import pwm3_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NPH = N_PH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [CW-1:0]    wr_data,
  output logic [NPH-1:0]   gate_hi,
  output logic [NPH-1:0]   gate_lo,
  output logic             sync_pulse,
  output logic             fault
);
  logic [CW-1:0]          sh_per, sh_dt, per_a, dt_a, cnt;
  logic [NPH-1:0][CW-1:0] sh_duty, duty_a;
  logic [2*NPH-1:0]       pol, ena;
  logic                   up, sync_q, run_ok;
  logic [NPH-1:0]         hi_act, lo_act;

  pwm3_regs #(.CW(CW), .NPH(NPH)) u_regs (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sh_per(sh_per), .sh_dt(sh_dt),
    .sh_duty(sh_duty), .pol(pol), .ena(ena), .fault(fault)
  );

  pwm3_timebase #(.CW(CW), .NPH(NPH)) u_tb (
    .clk(clk), .rst_n(rst_n), .sh_per(sh_per), .sh_dt(sh_dt),
    .sh_duty(sh_duty), .cnt(cnt), .up(up), .per_a(per_a), .dt_a(dt_a),
    .duty_a(duty_a), .sync_q(sync_q)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    pwm3_leg #(.CW(CW)) u_leg (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .per(per_a),
      .duty(duty_a[k]), .dt(dt_a), .hi_q(hi_act[k]), .lo_q(lo_act[k])
    );
  end

  // Trip gating is combinational so it acts without a clock edge
  assign run_ok     = trip_n && !fault;
  assign gate_hi    = (hi_act & ena[NPH-1:0]   & {NPH{run_ok}}) ^ pol[NPH-1:0];
  assign gate_lo    = (lo_act & ena[2*NPH-1:NPH] & {NPH{run_ok}}) ^ pol[2*NPH-1:NPH];
  assign sync_pulse = sync_q;
endmodule

// File: rtl/pwm3_ctrl_chk.sv
module pwm3_ctrl_chk
  import pwm3_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NPH = N_PH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trip_n,
  input logic             wr_en,
  input logic [ADR_W-1:0] wr_addr,
  input logic [NPH-1:0]   gate_hi,
  input logic [NPH-1:0]   gate_lo,
  input logic             sync_pulse,
  input logic             fault,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    per_a,
  input logic [2*NPH-1:0] pol,
  input logic [2*NPH-1:0] ena,
  input logic [NPH-1:0]   hi_act,
  input logic [NPH-1:0]   lo_act
);
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_a);

  a_r1_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && per_a != '0) |=> !sync_pulse);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_act & lo_act) == '0);

  a_r6_masked_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi ^ pol[NPH-1:0]) & ~ena[NPH-1:0]) == '0 &&
    ((gate_lo ^ pol[2*NPH-1:NPH]) & ~ena[2*NPH-1:NPH]) == '0);

  a_r7_trip_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> (gate_hi == pol[NPH-1:0] && gate_lo == pol[2*NPH-1:NPH]));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(wr_en && wr_addr == ADR_CLR)) |=> fault);
endmodule

bind pwm3_ctrl pwm3_ctrl_chk #(.CW(CW), .NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .sync_pulse(sync_pulse), .fault(fault),
  .cnt(cnt), .per_a(per_a), .pol(pol), .ena(ena), .hi_act(hi_act), .lo_act(lo_act)
);

// File: tb/test_pwm3_ctrl.sv
module test_pwm3_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, trip_n, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  gate_hi, gate_lo;
  logic        sync_pulse, fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_per, m_ovl;
  int m_hi[3];
  int m_lo[3];

  always #4 clk = ~clk;

  pwm3_ctrl i_pwm3_ctrl (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .sync_pulse(sync_pulse), .fault(fault)
  );

  // period, duty, dead, expected high count, expected low count
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{10,  5, 0, 10, 10},
    '{10,  5, 2,  6,  6},
    '{10,  0, 1,  0, 18},
    '{10, 10, 0, 20,  0},
    '{10, 15, 1, 18,  0},
    '{ 8,  3, 5,  0,  0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic next_sync();
    do @(negedge clk); while (!sync_pulse);
  endtask

  // Counts raw pin highs from one sync to the cycle before the next
  task automatic measure();
    while (!sync_pulse) @(negedge clk);
    m_per = 0; m_ovl = 0;
    for (int k = 0; k < 3; k++) begin m_hi[k] = 0; m_lo[k] = 0; end
    do begin
      m_per++;
      for (int k = 0; k < 3; k++) begin
        m_hi[k] += int'(gate_hi[k]);
        m_lo[k] += int'(gate_lo[k]);
      end
      if ((gate_hi & gate_lo) != 3'b000) m_ovl++;
      @(negedge clk);
    end while (!sync_pulse && m_per < 1000);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trip_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R6 reset: all enables off, all pins 0; R1 fault clear
    check("R6 reset gate_hi", int'(gate_hi), 0);
    check("R6 reset gate_lo", int'(gate_lo), 0);
    check("R1 reset fault", int'(fault), 0);

    wr(3'd6, 16'h003F);

    // Table of width vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 16'(VEC[i][0]));
      wr(3'd1, 16'(VEC[i][1]));
      wr(3'd2, 16'(VEC[i][1]));
      wr(3'd3, 16'(VEC[i][1]));
      wr(3'd4, 16'(VEC[i][2]));
      repeat (3) next_sync();
      measure();
      check("R1 period length", m_per, 2 * VEC[i][0]);
      for (int k = 0; k < 3; k++) begin
        check("R2/R3 high width", m_hi[k], VEC[i][3]);
        check("R3 low width", m_lo[k], VEC[i][4]);
      end
      check("R3 no overlap", m_ovl, 0);
    end

    // R2 per-phase duties, R9 addresses
    wr(3'd0, 16'd10);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd6);
    wr(3'd4, 16'd0);
    repeat (3) next_sync();
    measure();
    check("R2 phase0 high", m_hi[0], 4);
    check("R2 phase1 high", m_hi[1], 8);
    check("R9 phase2 high", m_hi[2], 12);
    check("R2 phase2 low", m_lo[2], 8);

    // R4 write during a running period
    fork
      measure();
      begin
        repeat (3) @(posedge clk);
        wr(3'd1, 16'd8);
      end
    join
    check("R4 old duty kept", m_hi[0], 4);
    measure();
    check("R4 new duty applied", m_hi[0], 16);

    // R5 polarity, all outputs active-low
    wr(3'd5, 16'h003F);
    next_sync();
    measure();
    check("R5 inverted hi0", m_hi[0], 4);
    check("R5 inverted hi1", m_hi[1], 12);
    check("R5 inverted lo0", m_lo[0], 16);
    check("R5 inverted lo2", m_lo[2], 12);

    // R6 mask one output
    wr(3'd5, 16'h0000);
    wr(3'd6, 16'h003E);
    next_sync();
    measure();
    check("R6 masked hi0", m_hi[0], 0);
    check("R6 unmasked lo0", m_lo[0], 4);
    check("R6 unmasked hi1", m_hi[1], 8);

    // R7 trip, asynchronous
    wr(3'd6, 16'h003F);
    wr(3'd5, 16'h0005);
    next_sync();
    repeat (3) @(negedge clk);
    trip_n = 1'b0;
    #1;
    check("R7 trip hi", int'(gate_hi), 5);
    check("R7 trip lo", int'(gate_lo), 0);
    repeat (4) @(negedge clk);
    check("R8 fault set", int'(fault), 1);
    wr(3'd7, 16'h0000);
    repeat (2) @(negedge clk);
    check("R8 clear ignored in trip", int'(fault), 1);
    trip_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 still off hi", int'(gate_hi), 5);
    check("R8 still off lo", int'(gate_lo), 0);
    check("R8 fault held", int'(fault), 1);
    wr(3'd7, 16'h0000);
    @(negedge clk);
    check("R8 fault cleared", int'(fault), 0);
    wr(3'd5, 16'h0000);
    next_sync();
    measure();
    check("R8 resumed hi0", m_hi[0], 16);
    check("R8 resumed lo1", m_lo[1], 12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule